// File: doc/BRIEF.md
# Parallel Flash Bus Command Interface

This block models the host-facing side of a parallel NOR-style flash device inside a synchronous design. The asynchronous bus pins are sampled on the system clock: chip enable, output enable, write enable, a bus reset pin and a word/byte width select. Reads return data from an internal word array. Writes are turned into single bus-cycle strobes that feed a command-sequence state machine.

The state machine accepts an unlock pair of writes at two fixed addresses, followed by a command. The commands are program, block erase (which takes a second unlock pair and then a confirm code at an address inside the target block) and boot-region lockout. Program and erase hold a busy flag for a configurable number of cycles and change the array only when that count ends. While busy, reads return a status word instead of array data. Tri-state pins are represented as a data-out bus with one enable per byte lane.

The array is split into four erase blocks: a boot block at the lowest addresses, two equal parameter blocks, and a main block that fills the rest.

Top module: `flash_cmd_if`

## Requirements
- R1: Data outputs are enabled (`dq_oe` non-zero) only while `ce_n`=0, `oe_n`=0, `we_n`=1 and `bus_rst_n`=1; in every other pin state `dq_oe`=2'b00 and the array is not changed.
- R2: After `rst_n` every array word reads 16'hFFFF, and a word-mode read (`word_mode`=1) drives the addressed word on `dq_out` with `dq_oe`=2'b11.
- R3: With `word_mode`=0, `dq_in[15]` is the byte-select address bit (0 = bits 7:0, 1 = bits 15:8 of the word). A read places the selected byte on `dq_out[7:0]` with `dq_oe`=2'b01. Write data is taken only from `dq_in[7:0]`.
- R4: A write cycle is the overlap of `ce_n`=0 and `we_n`=0 with `oe_n`=1. Its address is taken when the later of the two falls, and its data is the value held when the first of the two rises. An overlap with `oe_n`=0 is not a write.
- R5: Commands are recognised on `dq_in[7:0]` only, with bits 15:8 ignored. The unlock pair is AA at address 0x15 and then 55 at 0x2A. After the pair, a command at 0x15 selects the operation: A0 = program the next write, 80 = erase (then AA@0x15, 55@0x2A, and 30 at any address in the target block), 40 = lock the boot block.
- R6: A write that does not match the expected step returns the sequencer to read mode, and no operation follows.
- R7: Program sets the addressed word to old AND data. In byte mode only the selected byte lane changes.
- R8: Erase sets every word of the addressed block to 16'hFFFF and leaves the other blocks unchanged. The blocks are boot [0,16), parameter A [16,24), parameter B [24,32) and main [32,64).
- R9: `busy` rises in the cycle after the final write of a program or erase and stays high for exactly BUSY_CYC (32) cycles. The array changes when `busy` falls. Writes made while `busy` is high are ignored.
- R10: While `busy` is high, a read returns a status word in place of array data. All bits are 0 except bit 6, which flips at the start of each read. The first such read after `rst_n` returns 16'h0040.
- R11: `bus_rst_n`=0 aborts a running operation: `busy` drops on the next cycle, the outputs are disabled and the array keeps its prior content. Normal operation resumes once the pin is high again.
- R12: After the lock command, program and erase aimed at the boot block leave it unchanged and never raise `busy`; other blocks still program. Only `rst_n` clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| bus_rst_n | input | 1 | Bus reset pin, active low |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| addr | input | 6 | Word address |
| dq_in | input | 16 | Data pins as seen by the device |
| dq_out | output | 16 | Data driven onto the pins |
| dq_oe | output | 2 | Per-lane drive enable (bit 0 low byte, bit 1 high byte) |
| busy | output | 1 | Program or erase in progress |

## Verification
Program is exercised with word data, with repeated programs to one word (which shows AND behaviour rather than overwrite), and with byte-lane data carrying garbage in bits 14:8 (which shows that the lane select and the data source are separated correctly). Write cycles are driven as WE-controlled, CE-controlled and skewed, where address and data change between the two edges, so that capture on the later fall and on the first rise is told apart from capture on either edge alone. The command stream includes broken unlocks, writes with OE low, writes during busy and boot-targeted operations after locking. Each of these must leave the array and `busy` untouched. Erase on one parameter block, with the neighbouring blocks read back, checks the block boundaries.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    S_READ, S_U1, S_U2, S_PROG, S_E0, S_E1, S_E2, S_BUSY
  } seq_st_t;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_LOCK  = 8'h40;
  localparam logic [7:0] CMD_CONF  = 8'h30;

  // Erase block index: 0 boot, 1/2 parameter, 3 main
  function automatic logic [1:0] blk_of(input int unsigned a,
                                        input int unsigned boot_w,
                                        input int unsigned par_w);
    if (a < boot_w) return 2'd0;
    if (a < boot_w + par_w) return 2'd1;
    if (a < boot_w + 2 * par_w) return 2'd2;
    return 2'd3;
  endfunction

endpackage

// File: rtl/fcmd_bus_decode.sv
module fcmd_bus_decode #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          word_mode,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic          wr_lane,
  output logic          wr_byte,
  output logic [15:0]   wr_data,
  output logic          rd_act,
  output logic          rd_start
);

  logic wr_act, wr_q, rd_q;

  assign wr_act   = pin_rst_n & ~ce_n & ~we_n & oe_n;
  assign rd_act   = pin_rst_n & ~ce_n & ~oe_n & we_n;
  assign rd_start = rd_act & ~rd_q;
  assign wr_stb   = pin_rst_n & wr_q & ~wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_addr <= '0;
      wr_lane <= 1'b0;
      wr_byte <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      // later falling edge of CE/WE opens the overlap: take address
      if (wr_act && !wr_q) begin
        wr_addr <= addr;
        wr_lane <= ~word_mode & dq_in[15];
        wr_byte <= ~word_mode;
      end
      // data follows the pins until the overlap closes
      if (wr_act) wr_data <= dq_in;
    end
  end

endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW       = 6,
  parameter int unsigned BOOT_W   = 16,
  parameter int unsigned PAR_W    = 8,
  parameter int unsigned BUSY_CYC = 32,
  parameter logic [AW-1:0] UA1    = 'h15,
  parameter logic [AW-1:0] UA2    = 'h2A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          wr_lane,
  input  logic          wr_byte,
  output logic          busy,
  output logic          commit,
  output logic          op_erase,
  output logic [AW-1:0] op_addr,
  output logic [15:0]   op_data,
  output logic          op_lane,
  output logic          op_byte,
  output logic          locked
);

  localparam int unsigned CW = $clog2(BUSY_CYC + 1);

  seq_st_t       st, st_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          ld_op, ld_erase, lock_set, fin;
  logic [7:0]    cmd;
  logic          at1, at2, boot_hit;

  assign cmd      = wr_data[7:0];
  assign at1      = (wr_addr == UA1);
  assign at2      = (wr_addr == UA2);
  assign boot_hit = locked && (blk_of(32'(wr_addr), BOOT_W, PAR_W) == 2'd0);

  always_comb begin
    st_d     = st;
    cnt_d    = cnt;
    ld_op    = 1'b0;
    ld_erase = 1'b0;
    lock_set = 1'b0;
    fin      = 1'b0;
    unique case (st)
      S_READ: if (wr_stb) st_d = (at1 && cmd == CMD_KEY1) ? S_U1 : S_READ;
      S_U1:   if (wr_stb) st_d = (at2 && cmd == CMD_KEY2) ? S_U2 : S_READ;
      S_U2: if (wr_stb) begin
        st_d = S_READ;
        if (at1 && cmd == CMD_PROG) st_d = S_PROG;
        else if (at1 && cmd == CMD_ERASE) st_d = S_E0;
        else if (at1 && cmd == CMD_LOCK) lock_set = 1'b1;
      end
      S_PROG: if (wr_stb) begin
        st_d = S_READ;
        if (!boot_hit) begin
          ld_op = 1'b1;
          st_d  = S_BUSY;
          cnt_d = CW'(BUSY_CYC - 1);
        end
      end
      S_E0: if (wr_stb) st_d = (at1 && cmd == CMD_KEY1) ? S_E1 : S_READ;
      S_E1: if (wr_stb) st_d = (at2 && cmd == CMD_KEY2) ? S_E2 : S_READ;
      S_E2: if (wr_stb) begin
        st_d = S_READ;
        if (cmd == CMD_CONF && !boot_hit) begin
          ld_op    = 1'b1;
          ld_erase = 1'b1;
          st_d     = S_BUSY;
          cnt_d    = CW'(BUSY_CYC - 1);
        end
      end
      S_BUSY: begin
        if (cnt == '0) begin
          fin  = 1'b1;
          st_d = S_READ;
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_READ;
      cnt      <= '0;
      locked   <= 1'b0;
      op_erase <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
      op_lane  <= 1'b0;
      op_byte  <= 1'b0;
    end else begin
      if (!pin_rst_n) begin
        st  <= S_READ;
        cnt <= '0;
      end else begin
        st  <= st_d;
        cnt <= cnt_d;
      end
      if (lock_set) locked <= 1'b1;
      if (ld_op) begin
        op_erase <= ld_erase;
        op_addr  <= wr_addr;
        op_data  <= wr_data;
        op_lane  <= wr_lane;
        op_byte  <= wr_byte;
      end
    end
  end

  assign busy   = (st == S_BUSY);
  assign commit = fin & pin_rst_n;

  AST_RST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_rst_n |=> !busy); // R11

  AST_BUSY_IGNORES_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb && cnt != '0 && pin_rst_n) |=> busy); // R9

  AST_LOCK_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && locked) |-> blk_of(32'(op_addr), BOOT_W, PAR_W) != 2'd0); // R12

endmodule

// File: rtl/fcmd_array.sv
module fcmd_array
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW     = 6,
  parameter int unsigned BOOT_W = 16,
  parameter int unsigned PAR_W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          op_erase,
  input  logic [AW-1:0] op_addr,
  input  logic [15:0]   op_data,
  input  logic          op_lane,
  input  logic          op_byte,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_word
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [15:0] mem [DEPTH];
  logic [15:0] pmask;
  logic [1:0]  tgt_blk;

  assign tgt_blk = blk_of(32'(op_addr), BOOT_W, PAR_W);
  assign pmask   = !op_byte ? op_data :
                   op_lane  ? {op_data[7:0], 8'hFF} : {8'hFF, op_data[7:0]};
  assign rd_word = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
    end else if (commit) begin
      if (op_erase) begin
        for (int unsigned i = 0; i < DEPTH; i++)
          if (blk_of(i, BOOT_W, PAR_W) == tgt_blk) mem[i] <= 16'hFFFF;
      end else begin
        mem[op_addr] <= mem[op_addr] & pmask;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if #(
  parameter int unsigned AW       = 6,
  parameter int unsigned BOOT_W   = 16,
  parameter int unsigned PAR_W    = 8,
  parameter int unsigned BUSY_CYC = 32,
  parameter logic [AW-1:0] UA1    = 'h15,
  parameter logic [AW-1:0] UA2    = 'h2A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          bus_rst_n,
  input  logic          word_mode,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic [1:0]    dq_oe,
  output logic          busy
);

  logic          wr_stb, wr_lane, wr_byte, rd_act, rd_start;
  logic [AW-1:0] wr_addr, op_addr;
  logic [15:0]   wr_data, op_data, rd_word, src_word;
  logic          commit, op_erase, op_lane, op_byte, locked;
  logic          tog, rd_lane;

  fcmd_bus_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(bus_rst_n),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .word_mode(word_mode),
    .addr(addr), .dq_in(dq_in),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_lane(wr_lane), .wr_byte(wr_byte),
    .wr_data(wr_data), .rd_act(rd_act), .rd_start(rd_start)
  );

  fcmd_seq #(.AW(AW), .BOOT_W(BOOT_W), .PAR_W(PAR_W), .BUSY_CYC(BUSY_CYC),
             .UA1(UA1), .UA2(UA2)) u_seq (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(bus_rst_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_lane(wr_lane), .wr_byte(wr_byte),
    .busy(busy), .commit(commit), .op_erase(op_erase), .op_addr(op_addr),
    .op_data(op_data), .op_lane(op_lane), .op_byte(op_byte), .locked(locked)
  );

  fcmd_array #(.AW(AW), .BOOT_W(BOOT_W), .PAR_W(PAR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .op_erase(op_erase),
    .op_addr(op_addr), .op_data(op_data), .op_lane(op_lane), .op_byte(op_byte),
    .rd_addr(addr), .rd_word(rd_word)
  );

  // status toggle bit flips on every read that starts while busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else if (rd_start && busy) tog <= ~tog;
  end

  assign rd_lane  = ~word_mode & dq_in[15];
  assign src_word = busy ? {9'd0, tog, 6'd0} : rd_word;
  assign dq_out   = word_mode ? src_word :
                    {8'h00, rd_lane ? src_word[15:8] : src_word[7:0]};
  assign dq_oe    = {rd_act & word_mode, rd_act};

  AST_HIZ_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n || !bus_rst_n) |-> dq_oe == 2'b00); // R1

  AST_BYTE_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> !dq_oe[1]); // R3

endmodule

// File: tb/flash_cmd_if_tb_top.sv
module flash_cmd_if_tb_top;

  localparam int BUSY_CYC = 32;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, bus_rst_n, word_mode, busy;
  logic [5:0]  addr;
  logic [15:0] dq_in, dq_out;
  logic [1:0]  dq_oe;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  logic [15:0] model [64];
  logic [15:0] q_exp [$];
  logic [15:0] q_mask [$];
  logic [1:0]  q_oe [$];
  string       q_tag [$];

  always #2 clk = ~clk;

  flash_cmd_if dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .bus_rst_n(bus_rst_n), .word_mode(word_mode), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per read cycle
  initial forever begin
    @(posedge clk);
    #1;
    if (q_exp.size() > 0) begin
      logic [15:0] e, m;
      logic [1:0]  o;
      string       t;
      e = q_exp.pop_front(); m = q_mask.pop_front();
      o = q_oe.pop_front();  t = q_tag.pop_front();
      chk(dq_oe == o, {t, " oe"}, {14'd0, dq_oe}, {14'd0, o});
      if (o != 2'b00) chk((dq_out & m) == (e & m), {t, " data"}, dq_out & m, e & m);
    end
  end

  task automatic rd(input logic [5:0] a, input logic lane, input logic wm,
                    input logic [15:0] e, input logic [15:0] m,
                    input logic [1:0] o, input string tag);
    @(negedge clk);
    word_mode = wm; addr = a; dq_in = {lane, 15'd0};
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    q_exp.push_back(e); q_mask.push_back(m); q_oe.push_back(o); q_tag.push_back(tag);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; word_mode = 1'b1;
  endtask

  task automatic rdm(input logic [5:0] a, input string tag);
    rd(a, 1'b0, 1'b1, model[a], 16'hFFFF, 2'b11, tag);
  endtask

  task automatic gate(input logic c, input logic o, input logic w, input string tag);
    @(negedge clk);
    addr = 6'h05; ce_n = c; oe_n = o; we_n = w; dq_in = 16'h0000;
    q_exp.push_back(16'h0); q_mask.push_back(16'h0); q_oe.push_back(2'b00); q_tag.push_back(tag);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  // CE-controlled write: WE low first, CE pulses
  task automatic bus_wr_ce(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; dq_in = d; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic unlock();
    bus_wr(6'h15, 16'hC3AA);
    bus_wr_ce(6'h2A, 16'h9955);
  endtask

  task automatic mprog(input logic [5:0] a, input logic [15:0] d);
    model[a] = model[a] & d;
  endtask

  task automatic mperase(input int lo, input int hi);
    for (int i = lo; i < hi; i++) model[i] = 16'hFFFF;
  endtask

  task automatic prog(input logic [5:0] a, input logic [15:0] d);
    unlock(); bus_wr(6'h15, 16'h7EA0); bus_wr(a, d);
  endtask

  task automatic erase(input logic [5:0] a);
    unlock(); bus_wr(6'h15, 16'h0080); unlock(); bus_wr(a, 16'h5A30);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    @(negedge clk);
    while (busy && n < 500) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; bus_rst_n = 1'b1;
    word_mode = 1'b1; addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R9 busy after reset", {15'd0, busy}, 16'h0);

    // R1 gating
    gate(1'b0, 1'b1, 1'b1, "R1 oe high");
    gate(1'b1, 1'b0, 1'b1, "R1 ce high");
    gate(1'b0, 1'b0, 1'b0, "R1 we low");
    rdm(6'h05, "R2 erased after reset");
    rdm(6'h3F, "R2 top word");

    // R5/R7/R9 program and busy length
    prog(6'h20, 16'h1234); mprog(6'h20, 16'h1234);
    wait_idle(n);
    chk(n == BUSY_CYC, "R9 busy length", 16'(n), 16'(BUSY_CYC));
    rdm(6'h20, "R7 program word");
    prog(6'h20, 16'hFF0F); mprog(6'h20, 16'hFF0F);
    wait_idle(n);
    rdm(6'h20, "R7 program AND");

    // R3 byte reads
    rd(6'h20, 1'b1, 1'b0, 16'h0012, 16'h00FF, 2'b01, "R3 byte hi lane");
    rd(6'h20, 1'b0, 1'b0, 16'h0004, 16'h00FF, 2'b01, "R3 byte lo lane");

    // R3/R7 byte program with junk in bits 14:8
    unlock(); bus_wr(6'h15, 16'h00A0);
    word_mode = 1'b0;
    bus_wr(6'h30, {1'b1, 7'h7F, 8'h5A});
    @(negedge clk); word_mode = 1'b1;
    mprog(6'h30, 16'h5AFF);
    wait_idle(n);
    rdm(6'h30, "R7 byte program lane");

    // R4 skewed write: addr at later fall, data at first rise
    unlock(); bus_wr(6'h15, 16'h00A0);
    @(negedge clk); addr = 6'h3F; ce_n = 1'b0; oe_n = 1'b1; dq_in = 16'h0000;
    @(negedge clk); addr = 6'h25; we_n = 1'b0; dq_in = 16'hA5C3;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); dq_in = 16'h0000; addr = 6'h3F;
    @(negedge clk); ce_n = 1'b1;
    mprog(6'h25, 16'hA5C3);
    wait_idle(n);
    rdm(6'h25, "R4 capture addr/data");
    rdm(6'h3F, "R4 early addr untouched");

    // R6 broken sequence
    bus_wr(6'h15, 16'h00AA); bus_wr(6'h2A, 16'h0012);
    bus_wr(6'h2A, 16'h0055); bus_wr(6'h15, 16'h00A0); bus_wr(6'h21, 16'h0000);
    @(negedge clk);
    chk(busy == 1'b0, "R6 no busy after break", {15'd0, busy}, 16'h0);
    rdm(6'h21, "R6 no program after break");

    // R4 write with OE low is not a write
    @(negedge clk); addr = 6'h15; dq_in = 16'h00AA; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    bus_wr_ce(6'h2A, 16'h0055); bus_wr(6'h15, 16'h00A0); bus_wr(6'h26, 16'h0000);
    @(negedge clk);
    chk(busy == 1'b0, "R4 oe-low write ignored", {15'd0, busy}, 16'h0);
    rdm(6'h26, "R4 oe-low write no program");

    // R8 erase of parameter block A
    prog(6'h10, 16'h0000); mprog(6'h10, 16'h0000); wait_idle(n);
    prog(6'h18, 16'h1111); mprog(6'h18, 16'h1111); wait_idle(n);
    erase(6'h14); mperase(16, 24); wait_idle(n);
    rdm(6'h10, "R8 erased word in block");
    rdm(6'h18, "R8 neighbour block kept");
    rdm(6'h20, "R8 main block kept");

    // R10 status word, R9 write during busy ignored
    prog(6'h27, 16'h8001); mprog(6'h27, 16'h8001);
    rd(6'h27, 1'b0, 1'b1, 16'h0040, 16'hFFFF, 2'b11, "R10 first status");
    rd(6'h27, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 2'b11, "R10 second status");
    bus_wr(6'h28, 16'h0000);
    wait_idle(n);
    rdm(6'h27, "R10 data after busy");
    rdm(6'h28, "R9 write during busy ignored");

    // R11 abort by bus reset
    prog(6'h22, 16'h00FF); mprog(6'h22, 16'h00FF); wait_idle(n);
    erase(6'h22);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R11 busy before abort", {15'd0, busy}, 16'h1);
    bus_rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R11 busy dropped", {15'd0, busy}, 16'h0);
    rd(6'h22, 1'b0, 1'b1, 16'h0, 16'h0, 2'b00, "R11 outputs off");
    bus_rst_n = 1'b1;
    repeat (BUSY_CYC + 4) @(negedge clk);
    rdm(6'h22, "R11 array kept");

    // R12 boot lockout
    prog(6'h03, 16'h0F0F); mprog(6'h03, 16'h0F0F); wait_idle(n);
    unlock(); bus_wr(6'h15, 16'h0040);
    prog(6'h03, 16'h0000);
    @(negedge clk);
    chk(busy == 1'b0, "R12 locked program no busy", {15'd0, busy}, 16'h0);
    rdm(6'h03, "R12 locked program");
    erase(6'h05);
    @(negedge clk);
    chk(busy == 1'b0, "R12 locked erase no busy", {15'd0, busy}, 16'h0);
    rdm(6'h03, "R12 locked erase");
    prog(6'h29, 16'h1357); mprog(6'h29, 16'h1357); wait_idle(n);
    rdm(6'h29, "R12 main still programs");

    repeat (3) @(negedge clk);
    done_flag = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule